// File: doc/BRIEF.md
# Chip-Select Decoder with Online Spare Substitution

This block resolves a normalized memory-controller input address to the rank that responds to it. It holds no state of its own for configuration. A bank of chip-select entries comes in on flattened configuration ports, and each entry carries a base, a don't-care mask and an enable bit. Every enabled entry compares the address against its base on the bit positions that its mask leaves significant. The lowest-numbered matching entry is taken as the responder.

A rank can be retired in favour of a spare. Configuration names a failed rank number and a spare rank number, and each number has its own valid bit. When the responder is the failed rank, the reported rank becomes the spare. The spare entry's own base, mask and enable play no part in this decision. If a swap is called for but the spare number cannot be used, the block raises a fault flag and keeps the responder as the rank.

A request is captured on `lookup_vld_i`, and the result appears with `result_vld_o` one clock later. Result outputs hold their value between requests.

Top module: `cs_spare_decoder`

## Requirements
- R1: An enabled entry i responds when (addr & ~mask[i]) == (base[i] & ~mask[i]); bits set in the mask are don't-care.
- R2: An entry whose enable bit is 0 never responds, whatever its base and mask; with no enabled responder the lookup is a miss.
- R3: When several entries respond, the lowest index is reported in `hit_idx_o`.
- R4: On a miss, `hit_o`=0, `hit_idx_o`=0, `rank_o`=0, `swapped_o`=0 and `spare_fault_o`=0, even when the failed-rank settings are valid.
- R5: When the failed-rank valid bit is 0, no substitution occurs and `rank_o` equals the responding index, whatever the spare settings are.
- R6: When the responding index differs from the failed-rank number, no substitution occurs and `rank_o` equals the responding index.
- R7: When the failed-rank number is valid and equals the responding index, and the spare number is valid and below the entry count, `rank_o` is the spare number and `swapped_o`=1. This holds even when the spare entry is disabled.
- R8: When a substitution is called for but the spare valid bit is 0 or the spare number is at or above the entry count, `spare_fault_o`=1, `swapped_o`=0 and `rank_o` is the responding index. `swapped_o` and `spare_fault_o` are never 1 together.
- R9: `result_vld_o` is 1 exactly one clock after a clock with `lookup_vld_i`=1. Result outputs change only on such clocks and otherwise hold their value.
- R10: After reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| lookup_vld_i | input | 1 | Capture a lookup this clock |
| lookup_addr_i | input | ADDR_W | Normalized input address |
| cs_base_i | input | NUM_CS*ADDR_W | Entry bases, entry i at bits [i*ADDR_W +: ADDR_W] |
| cs_mask_i | input | NUM_CS*ADDR_W | Entry don't-care masks, same layout |
| cs_en_i | input | NUM_CS | Entry enables, bit i for entry i |
| fail_rank_i | input | RANK_W | Failed rank number |
| fail_vld_i | input | 1 | Failed rank number is valid |
| spare_rank_i | input | RANK_W | Spare rank number |
| spare_vld_i | input | 1 | Spare rank number is valid |
| result_vld_o | output | 1 | Result of the lookup captured on the previous clock |
| hit_o | output | 1 | Some enabled entry responded |
| hit_idx_o | output | IDX_W | Index of the responding entry |
| rank_o | output | RANK_W | Rank after spare substitution |
| swapped_o | output | 1 | Spare substitution was applied |
| spare_fault_o | output | 1 | Substitution called for but spare unusable |

## Verification
The address patterns are chosen so that some hit exactly one entry and some hit two entries that overlap, one of which has a wider mask. This separates a correct masked compare from a plain equality test, and lowest-index priority from highest-index priority. The same overlapping address is then applied with the lower entry disabled, and an address is applied whose only candidate is disabled. These show that the enable gates the match. The spare settings are varied around a fixed responder: a matching failed rank, a non-matching one, an invalid failed rank, an invalid spare, an out-of-range spare and a disabled spare entry. Together these separate the plain swap, the no-swap cases and the fault path. Extra checks cover the hold behaviour between requests and failed-rank settings applied on a miss.

// File: rtl/cs_dec_pkg.sv
package cs_dec_pkg;

  // outcome of the spare substitution stage
  typedef enum logic [1:0] {
    SUB_NONE  = 2'd0,
    SUB_SWAP  = 2'd1,
    SUB_FAULT = 2'd2
  } sub_kind_e;

endpackage

// File: rtl/cs_entry_cmp.sv
module cs_entry_cmp #(
  parameter int unsigned ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] mask_i,
  input  logic              en_i,
  output logic              match_o
);

  logic [ADDR_W-1:0] care;

  always_comb begin
    care    = ~mask_i;
    match_o = en_i && ((addr_i & care) == (base_i & care));
  end

endmodule

// File: rtl/cs_first_pick.sv
module cs_first_pick #(
  parameter int unsigned NUM_CS = 8,
  localparam int unsigned IDX_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic [NUM_CS-1:0] match_i,
  output logic              found_o,
  output logic [IDX_W-1:0]  sel_o
);

  // scan downward so the lowest set bit is written last
  always_comb begin
    found_o = 1'b0;
    sel_o   = '0;
    for (int i = NUM_CS - 1; i >= 0; i--) begin
      if (match_i[i]) begin
        found_o = 1'b1;
        sel_o   = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/cs_spare_swap.sv
module cs_spare_swap
  import cs_dec_pkg::*;
#(
  parameter int unsigned NUM_CS = 8,
  parameter int unsigned RANK_W = 4,
  localparam int unsigned IDX_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic              found_i,
  input  logic [IDX_W-1:0]  sel_i,
  input  logic [RANK_W-1:0] fail_rank_i,
  input  logic              fail_vld_i,
  input  logic [RANK_W-1:0] spare_rank_i,
  input  logic              spare_vld_i,
  output logic [RANK_W-1:0] rank_o,
  output sub_kind_e         kind_o
);

  logic want_swap;
  logic spare_ok;

  always_comb begin
    want_swap = found_i && fail_vld_i && (fail_rank_i == RANK_W'(sel_i));
    spare_ok  = spare_vld_i && (32'(spare_rank_i) < 32'(NUM_CS));
    rank_o    = RANK_W'(sel_i);
    kind_o    = SUB_NONE;
    if (want_swap) begin
      if (spare_ok) begin
        rank_o = spare_rank_i;
        kind_o = SUB_SWAP;
      end else begin
        kind_o = SUB_FAULT;
      end
    end
  end

endmodule

// File: rtl/cs_spare_decoder.sv
module cs_spare_decoder
  import cs_dec_pkg::*;
#(
  parameter int unsigned NUM_CS = 8,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned RANK_W = 4,
  localparam int unsigned IDX_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     lookup_vld_i,
  input  logic [ADDR_W-1:0]        lookup_addr_i,
  input  logic [NUM_CS*ADDR_W-1:0] cs_base_i,
  input  logic [NUM_CS*ADDR_W-1:0] cs_mask_i,
  input  logic [NUM_CS-1:0]        cs_en_i,
  input  logic [RANK_W-1:0]        fail_rank_i,
  input  logic                     fail_vld_i,
  input  logic [RANK_W-1:0]        spare_rank_i,
  input  logic                     spare_vld_i,
  output logic                     result_vld_o,
  output logic                     hit_o,
  output logic [IDX_W-1:0]         hit_idx_o,
  output logic [RANK_W-1:0]        rank_o,
  output logic                     swapped_o,
  output logic                     spare_fault_o
);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  // per-entry comparators
  logic [NUM_CS-1:0] match_vec;

  for (genvar g = 0; g < NUM_CS; g++) begin : g_cmp
    cs_entry_cmp #(.ADDR_W(ADDR_W)) u_cmp (
      .addr_i  (lookup_addr_i),
      .base_i  (cs_base_i[g*ADDR_W +: ADDR_W]),
      .mask_i  (cs_mask_i[g*ADDR_W +: ADDR_W]),
      .en_i    (cs_en_i[g]),
      .match_o (match_vec[g])
    );
  end

  logic             found;
  logic [IDX_W-1:0] sel;

  cs_first_pick #(.NUM_CS(NUM_CS)) u_pick (
    .match_i (match_vec),
    .found_o (found),
    .sel_o   (sel)
  );

  logic [RANK_W-1:0] sub_rank;
  sub_kind_e         sub_kind;

  cs_spare_swap #(.NUM_CS(NUM_CS), .RANK_W(RANK_W)) u_swap (
    .found_i      (found),
    .sel_i        (sel),
    .fail_rank_i  (fail_rank_i),
    .fail_vld_i   (fail_vld_i),
    .spare_rank_i (spare_rank_i),
    .spare_vld_i  (spare_vld_i),
    .rank_o       (sub_rank),
    .kind_o       (sub_kind)
  );

  // next-state
  logic              vld_d, hit_d, swap_d, fault_d;
  logic [IDX_W-1:0]  idx_d;
  logic [RANK_W-1:0] rank_d;
  logic              vld_q, hit_q, swap_q, fault_q;
  logic [IDX_W-1:0]  idx_q;
  logic [RANK_W-1:0] rank_q;

  always_comb begin
    vld_d   = lookup_vld_i;
    hit_d   = hit_q;
    idx_d   = idx_q;
    rank_d  = rank_q;
    swap_d  = swap_q;
    fault_d = fault_q;
    if (lookup_vld_i) begin
      hit_d   = found;
      idx_d   = sel;
      rank_d  = found ? sub_rank : '0;
      swap_d  = (sub_kind == SUB_SWAP);
      fault_d = (sub_kind == SUB_FAULT);
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      vld_q   <= 1'b0;
      hit_q   <= 1'b0;
      idx_q   <= '0;
      rank_q  <= '0;
      swap_q  <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      vld_q   <= vld_d;
      hit_q   <= hit_d;
      idx_q   <= idx_d;
      rank_q  <= rank_d;
      swap_q  <= swap_d;
      fault_q <= fault_d;
    end
  end

  assign result_vld_o  = vld_q;
  assign hit_o         = hit_q;
  assign hit_idx_o     = idx_q;
  assign rank_o        = rank_q;
  assign swapped_o     = swap_q;
  assign spare_fault_o = fault_q;

  // R3
  first_hit_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    lookup_vld_i && found |->
      match_vec[sel] && ((match_vec & ((NUM_CS'(1) << sel) - NUM_CS'(1))) == '0));

  // R4
  miss_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    lookup_vld_i && !found |=> !hit_o && !swapped_o && !spare_fault_o && (rank_o == '0));

  // R7
  swap_rank_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    lookup_vld_i && (sub_kind == SUB_SWAP) |=> swapped_o && (rank_o == $past(spare_rank_i)));

  // R8
  swap_fault_excl_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    result_vld_o |-> !(swapped_o && spare_fault_o));

  // R9
  result_follow_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    lookup_vld_i |=> result_vld_o);

  // R9
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    !lookup_vld_i |=> !result_vld_o && $stable(rank_o) && $stable(hit_idx_o));

endmodule

// File: tb/cs_spare_decoder_test.sv
module cs_spare_decoder_test;

  localparam int unsigned NCS = 8;
  localparam int unsigned AW  = 32;
  localparam int unsigned RW  = 4;
  localparam int unsigned IW  = 3;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              lookup_vld_i = 1'b0;
  logic [AW-1:0]     lookup_addr_i = '0;
  logic [NCS*AW-1:0] cs_base_i = '0;
  logic [NCS*AW-1:0] cs_mask_i = '0;
  logic [NCS-1:0]    cs_en_i = '0;
  logic [RW-1:0]     fail_rank_i = '0;
  logic              fail_vld_i = 1'b0;
  logic [RW-1:0]     spare_rank_i = '0;
  logic              spare_vld_i = 1'b0;
  logic              result_vld_o, hit_o, swapped_o, spare_fault_o;
  logic [IW-1:0]     hit_idx_o;
  logic [RW-1:0]     rank_o;

  always #4 clk = ~clk;  // 125 MHz

  cs_spare_decoder #(.NUM_CS(NCS), .ADDR_W(AW), .RANK_W(RW)) uut (
    .clk(clk), .rst_n(rst_n), .lookup_vld_i(lookup_vld_i), .lookup_addr_i(lookup_addr_i),
    .cs_base_i(cs_base_i), .cs_mask_i(cs_mask_i), .cs_en_i(cs_en_i),
    .fail_rank_i(fail_rank_i), .fail_vld_i(fail_vld_i),
    .spare_rank_i(spare_rank_i), .spare_vld_i(spare_vld_i),
    .result_vld_o(result_vld_o), .hit_o(hit_o), .hit_idx_o(hit_idx_o), .rank_o(rank_o),
    .swapped_o(swapped_o), .spare_fault_o(spare_fault_o)
  );

  typedef struct packed {
    logic [31:0] addr;
    logic [7:0]  en;
    logic [3:0]  fail;
    logic        fv;
    logic [3:0]  spare;
    logic        sv;
    logic [7:0]  req;
    logic        e_hit;
    logic [2:0]  e_idx;
    logic [3:0]  e_rank;
    logic        e_swap;
    logic        e_fault;
  } vec_t;

  // entry i: base i<<8, mask 0xFF; entry 5 overridden: base 0x200, mask 0x3FF
  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{32'h0042, 8'hFF, 4'd0, 1'b0, 4'd0, 1'b0, 8'd1, 1'b1, 3'd0, 4'd0, 1'b0, 1'b0}, // R1 masked low bits
    '{32'h07FF, 8'hFF, 4'd2, 1'b1, 4'd6, 1'b1, 8'd6, 1'b1, 3'd7, 4'd7, 1'b0, 1'b0}, // R6 other rank failed
    '{32'h0310, 8'hFF, 4'd0, 1'b0, 4'd0, 1'b0, 8'd3, 1'b1, 3'd3, 4'd3, 1'b0, 1'b0}, // R3 3 beats 5
    '{32'h0310, 8'hF7, 4'd0, 1'b0, 4'd0, 1'b0, 8'd2, 1'b1, 3'd5, 4'd5, 1'b0, 1'b0}, // R2 3 off, wide mask of 5 hits
    '{32'h0900, 8'hFF, 4'd0, 1'b0, 4'd0, 1'b0, 8'd4, 1'b0, 3'd0, 4'd0, 1'b0, 1'b0}, // R4 plain miss
    '{32'h0400, 8'hFF, 4'd4, 1'b1, 4'd6, 1'b1, 8'd7, 1'b1, 3'd4, 4'd6, 1'b1, 1'b0}, // R7 swap
    '{32'h0400, 8'hBF, 4'd4, 1'b1, 4'd6, 1'b1, 8'd7, 1'b1, 3'd4, 4'd6, 1'b1, 1'b0}, // R7 spare entry disabled
    '{32'h0400, 8'hFF, 4'd4, 1'b1, 4'd6, 1'b0, 8'd8, 1'b1, 3'd4, 4'd4, 1'b0, 1'b1}, // R8 spare invalid
    '{32'h0400, 8'hFF, 4'd4, 1'b1, 4'd9, 1'b1, 8'd8, 1'b1, 3'd4, 4'd4, 1'b0, 1'b1}, // R8 spare out of range
    '{32'h0400, 8'hFF, 4'd4, 1'b0, 4'd6, 1'b1, 8'd5, 1'b1, 3'd4, 4'd4, 1'b0, 1'b0}, // R5 failed rank invalid
    '{32'h0400, 8'hFF, 4'd4, 1'b0, 4'd6, 1'b0, 8'd5, 1'b1, 3'd4, 4'd4, 1'b0, 1'b0}, // R5 both invalid
    '{32'h0100, 8'h00, 4'd0, 1'b0, 4'd0, 1'b0, 8'd2, 1'b0, 3'd0, 4'd0, 1'b0, 1'b0}, // R2 all disabled
    '{32'h0600, 8'hBF, 4'd6, 1'b1, 4'd1, 1'b1, 8'd4, 1'b0, 3'd0, 4'd0, 1'b0, 1'b0}  // R4 miss with failed rank set
  };

  int total = 0;
  int bad = 0;

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", what, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    @(negedge clk);
    lookup_addr_i = v.addr;
    cs_en_i       = v.en;
    fail_rank_i   = v.fail;
    fail_vld_i    = v.fv;
    spare_rank_i  = v.spare;
    spare_vld_i   = v.sv;
    lookup_vld_i  = 1'b1;
    @(negedge clk);
    lookup_vld_i  = 1'b0;
  endtask

  initial begin
    #(8 * 50000);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < NCS; i++) begin
      cs_base_i[i*AW +: AW] = AW'(i) << 8;
      cs_mask_i[i*AW +: AW] = 32'h0000_00FF;
    end
    cs_base_i[5*AW +: AW] = 32'h0000_0200;
    cs_mask_i[5*AW +: AW] = 32'h0000_03FF;

    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 result_vld", 32'(result_vld_o), 0);
    chk("R10 hit", 32'(hit_o), 0);
    chk("R10 idx", 32'(hit_idx_o), 0);
    chk("R10 rank", 32'(rank_o), 0);
    chk("R10 swapped/fault", {30'd0, swapped_o, spare_fault_o}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R10 idle after release", 32'(result_vld_o), 0);

    for (int k = 0; k < NV; k++) begin
      apply(VEC[k]);
      // now one negedge after the capturing edge
      chk($sformatf("vec %0d R%0d valid", k, VEC[k].req), 32'(result_vld_o), 1);
      chk($sformatf("vec %0d R%0d hit", k, VEC[k].req), 32'(hit_o), 32'(VEC[k].e_hit));
      chk($sformatf("vec %0d R%0d idx", k, VEC[k].req), 32'(hit_idx_o), 32'(VEC[k].e_idx));
      chk($sformatf("vec %0d R%0d rank", k, VEC[k].req), 32'(rank_o), 32'(VEC[k].e_rank));
      chk($sformatf("vec %0d R%0d swapped", k, VEC[k].req), 32'(swapped_o), 32'(VEC[k].e_swap));
      chk($sformatf("vec %0d R%0d fault", k, VEC[k].req), 32'(spare_fault_o), 32'(VEC[k].e_fault));
    end

    // R9 hold: a swap result, then change inputs without a request
    apply(VEC[5]);
    lookup_addr_i = 32'h0700;
    fail_vld_i    = 1'b0;
    @(negedge clk);
    chk("R9 valid drops", 32'(result_vld_o), 0);
    chk("R9 rank held", 32'(rank_o), 6);
    chk("R9 idx held", 32'(hit_idx_o), 4);
    chk("R9 swapped held", 32'(swapped_o), 1);

    // R9 back-to-back requests each give one result a clock later
    @(negedge clk);
    lookup_addr_i = 32'h0100;
    lookup_vld_i  = 1'b1;
    @(negedge clk);
    chk("R9 b2b first idx", 32'(hit_idx_o), 1);
    lookup_addr_i = 32'h0700;
    @(negedge clk);
    lookup_vld_i  = 1'b0;
    chk("R9 b2b second idx", 32'(hit_idx_o), 7);
    chk("R9 b2b second valid", 32'(result_vld_o), 1);

    // R10 reset mid-run clears outputs
    rst_n = 1'b0;
    @(negedge clk);
    chk("R10 reset clears rank", 32'(rank_o), 0);
    chk("R10 reset clears hit", 32'(hit_o), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule